// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block predicts the next result of an instruction from the results it has already produced. A direct-mapped table, indexed by the low bits of the instruction address and guarded by a tag from the remaining address bits, holds per entry the newest observed result, a candidate stride and a confirmed stride. The forecast is the newest result plus the confirmed stride, with all arithmetic wrapping at the value width.

A lookup port takes an address and, one clock later, returns a forecast together with a valid flag. An update port takes an address and the real result and trains the matching entry. If the tag does not match, the update replaces the entry. The confirmed stride changes under one of two hysteresis rules, chosen by a parameter. In the default rule, the candidate stride is promoted only when the same difference is seen twice in a row. In the other rule, a small saturating confidence counter gates the replacement.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every entry is invalid, so a lookup of any address returns `lk_pred_valid` = 0.
- R2: `lk_pred_valid` and `lk_pred_value` are registered. They reflect a lookup presented in the cycle before, and `lk_pred_valid` is 0 in any cycle that follows a cycle with `lk_en` = 0.
- R3: A lookup returns `lk_pred_valid` = 0 when the indexed entry is invalid or when its stored tag (address bits above the index) differs from the lookup address.
- R4: An update whose address misses allocates the entry: the newest result becomes the update result and both strides become zero, so the next forecast equals that result.
- R5: A valid forecast equals the stored newest result plus the confirmed stride, modulo 2^VAL_W. Negative strides and wrap past zero follow from this.
- R6: Every update that hits sets the candidate stride to (update result minus the stored newest result), and the newest result to the update result.
- R7: In two-delta mode (HYST = 0, default), the confirmed stride takes the new difference only when that difference equals the candidate stride already stored. Otherwise it keeps its value.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the forecast from the state before the update.
- R9: In confidence mode (HYST = 1), each hitting update moves a 2-bit counter up by one if the forecast was right and down by one if it was wrong, saturating at 3 and 0. The confirmed stride takes the new difference only if the counter was below CONF_THRESH before the update. An allocated entry starts at 0.
- R10: An update to an address with the same index but a different tag evicts the old entry, so a later lookup of the old address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_pred_valid | output | 1 | Forecast valid, one cycle after the request |
| lk_pred_value | output | VAL_W | Forecast value |
| up_en | input | 1 | Update request |
| up_pc | input | PC_W | Update instruction address |
| up_result | input | VAL_W | Real result used for training |

## Verification
Assertions check on every cycle that a valid forecast only follows a lookup request and that the output is clear straight after reset. They also check that the count of valid entries never drops outside reset, that in two-delta mode the confirmed stride moves only on a repeated difference, and that in confidence mode the counter steps by at most one. The arithmetic of the forecast, allocation on a miss, eviction by a conflicting tag, wrap-around, and the pre-update view of a same-cycle lookup can only be shown by the bench's scenarios. Those scenarios compare forecasts against values worked out by hand from the training sequences.

// File: rtl/svp_pkg.sv
package svp_pkg;

    typedef enum logic {
        HYST_TWO_DELTA  = 1'b0,
        HYST_CONFIDENCE = 1'b1
    } hyst_mode_e;

    localparam int unsigned CONF_W = 2;
    typedef logic [CONF_W-1:0] conf_t;

    // saturating step of the confidence counter
    function automatic conf_t conf_step(conf_t c, logic correct);
        if (correct) return (c == '1) ? c : c + 1'b1;
        else         return (c == '0) ? c : c - 1'b1;
    endfunction

endpackage

// File: rtl/svp_table.sv
module svp_table #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned ENT_W   = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [ENT_W-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [ENT_W-1:0] rb_data,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [ENT_W-1:0] w_data
);

    logic [ENT_W-1:0]   mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // both read ports see the state before this cycle's write
    assign ra_valid = valid_q[ra_idx];
    assign ra_data  = mem[ra_idx];
    assign rb_valid = valid_q[rb_idx];
    assign rb_data  = mem[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[w_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    // R1: entries only become invalid through reset
    p_valid_monotonic_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_q) >= $countones($past(valid_q)));

endmodule

// File: rtl/svp_train.sv
module svp_train
    import svp_pkg::*;
#(
    parameter int unsigned VAL_W       = 32,
    parameter int unsigned TAG_W       = 26,
    parameter hyst_mode_e  HYST        = HYST_TWO_DELTA,
    parameter int unsigned CONF_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_en,
    input  logic [TAG_W-1:0] up_tag,
    input  logic [VAL_W-1:0] up_result,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [VAL_W-1:0] in_last,
    input  logic [VAL_W-1:0] in_s1,
    input  logic [VAL_W-1:0] in_s2,
    input  conf_t            in_conf,
    output logic [VAL_W-1:0] out_last,
    output logic [VAL_W-1:0] out_s1,
    output logic [VAL_W-1:0] out_s2,
    output conf_t            out_conf
);

    logic             hit;
    logic [VAL_W-1:0] diff;
    logic [VAL_W-1:0] hit_s2;
    conf_t            hit_conf;

    assign hit  = in_valid && (in_tag == up_tag);
    assign diff = up_result - in_last;

    generate
        if (HYST == HYST_TWO_DELTA) begin : g_two_delta
            always_comb begin
                hit_s2   = (diff == in_s1) ? diff : in_s2;
                hit_conf = in_conf;
            end

            // R7: confirmed stride moves only on a repeated difference
            p_s2_needs_repeat_r7: assert property (@(posedge clk) disable iff (rst)
                (up_en && hit && (out_s2 != in_s2)) |-> (out_s2 == in_s1));
        end else begin : g_confidence
            logic  low_conf;
            conf_t conf_delta;
            assign low_conf   = (in_conf < conf_t'(CONF_THRESH));
            assign conf_delta = out_conf - in_conf;

            always_comb begin
                hit_s2   = low_conf ? diff : in_s2;
                hit_conf = conf_step(in_conf, diff == in_s2);
            end

            // R9: counter moves by at most one step per update
            p_conf_single_step_r9: assert property (@(posedge clk) disable iff (rst)
                (up_en && hit) |-> (conf_delta == '0 || conf_delta == conf_t'(1) || conf_delta == '1));
        end
    endgenerate

    always_comb begin
        out_last = up_result;
        if (hit) begin
            out_s1   = diff;
            out_s2   = hit_s2;
            out_conf = hit_conf;
        end else begin
            out_s1   = '0;
            out_s2   = '0;
            out_conf = '0;
        end
    end

endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor
    import svp_pkg::*;
#(
    parameter int unsigned ENTRIES     = 64,
    parameter int unsigned PC_W        = 32,
    parameter int unsigned VAL_W       = 32,
    parameter hyst_mode_e  HYST        = HYST_TWO_DELTA,
    parameter int unsigned CONF_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_pred_valid,
    output logic [VAL_W-1:0] lk_pred_value,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [VAL_W-1:0] up_result
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_W = PC_W - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [VAL_W-1:0] last;
        logic [VAL_W-1:0] s1;
        logic [VAL_W-1:0] s2;
        conf_t            conf;
    } entry_t;

    localparam int unsigned ENT_W = $bits(entry_t);

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             ra_valid, rb_valid;
    entry_t           ra_ent, rb_ent, wr_ent;

    assign lk_idx = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[PC_W-1:IDX_W];
    assign up_idx = up_pc[IDX_W-1:0];
    assign up_tag = up_pc[PC_W-1:IDX_W];

    svp_table #(
        .ENTRIES (ENTRIES),
        .ENT_W   (ENT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (lk_idx),
        .ra_valid (ra_valid),
        .ra_data  (ra_ent),
        .rb_idx   (up_idx),
        .rb_valid (rb_valid),
        .rb_data  (rb_ent),
        .we       (up_en),
        .w_idx    (up_idx),
        .w_data   (wr_ent)
    );

    assign wr_ent.tag = up_tag;

    svp_train #(
        .VAL_W       (VAL_W),
        .TAG_W       (TAG_W),
        .HYST        (HYST),
        .CONF_THRESH (CONF_THRESH)
    ) u_train (
        .clk       (clk),
        .rst       (rst),
        .up_en     (up_en),
        .up_tag    (up_tag),
        .up_result (up_result),
        .in_valid  (rb_valid),
        .in_tag    (rb_ent.tag),
        .in_last   (rb_ent.last),
        .in_s1     (rb_ent.s1),
        .in_s2     (rb_ent.s2),
        .in_conf   (rb_ent.conf),
        .out_last  (wr_ent.last),
        .out_s1    (wr_ent.s1),
        .out_s2    (wr_ent.s2),
        .out_conf  (wr_ent.conf)
    );

    logic lk_hit;
    assign lk_hit = ra_valid && (ra_ent.tag == lk_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_pred_valid <= 1'b0;
            lk_pred_value <= '0;
        end else begin
            lk_pred_valid <= lk_en && lk_hit;
            lk_pred_value <= ra_ent.last + ra_ent.s2;
        end
    end

    // R2: a valid forecast always answers a request from the cycle before
    p_valid_needs_request_r2: assert property (@(posedge clk) disable iff (rst)
        lk_pred_valid |-> $past(lk_en));

    // R1: output is clear in the first cycle after reset
    p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_pred_valid);

endmodule

// File: tb/test_stride_value_predictor.sv
module test_stride_value_predictor;
    import svp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_en = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_result = '0;
    logic        pv_a, pv_b;
    logic [31:0] pval_a, pval_b;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    stride_value_predictor #(.HYST(HYST_TWO_DELTA)) i_stride_value_predictor (
        .clk(clk), .rst(rst), .lk_en(lk_en), .lk_pc(lk_pc),
        .lk_pred_valid(pv_a), .lk_pred_value(pval_a),
        .up_en(up_en), .up_pc(up_pc), .up_result(up_result));

    stride_value_predictor #(.HYST(HYST_CONFIDENCE), .CONF_THRESH(2)) i_stride_value_predictor_conf (
        .clk(clk), .rst(rst), .lk_en(lk_en), .lk_pc(lk_pc),
        .lk_pred_valid(pv_b), .lk_pred_value(pval_b),
        .up_en(up_en), .up_pc(up_pc), .up_result(up_result));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] val);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_result = val;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    // which: 0 = two-delta instance, 1 = confidence instance
    task automatic look(input bit which, input logic [31:0] pc, input bit exp_v,
                        input logic [31:0] exp_val, input string req);
        logic v;
        logic [31:0] val;
        @(negedge clk);
        lk_en = 1'b1; lk_pc = pc;
        @(negedge clk);
        lk_en = 1'b0;
        v   = which ? pv_b : pv_a;
        val = which ? pval_b : pval_a;
        check(v == exp_v, req, {31'b0, v}, {31'b0, exp_v});
        if (exp_v) check(val == exp_val, req, val, exp_val);
    endtask

    task automatic t_reset;
        check(pv_a == 1'b0 && pv_b == 1'b0, "R1 output after reset", {31'b0, pv_a}, 32'h0);
        look(0, 32'h0000_0001, 1'b0, '0, "R1 lookup after reset");
        look(1, 32'h0000_0002, 1'b0, '0, "R1 lookup after reset conf");
    endtask

    task automatic t_alloc_and_idle;
        upd(32'h0000_0003, 32'd77);
        look(0, 32'h0000_0003, 1'b1, 32'd77, "R4 allocation predicts result");
        @(negedge clk);
        check(pv_a == 1'b0, "R2 valid low without request", {31'b0, pv_a}, 32'h0);
    endtask

    task automatic t_two_delta;
        logic [31:0] pc = 32'h0000_0004;
        upd(pc, 32'd100);
        upd(pc, 32'd104);
        look(0, pc, 1'b1, 32'd104, "R7 single difference not promoted");
        upd(pc, 32'd108);
        look(0, pc, 1'b1, 32'd112, "R5 R7 repeated difference promoted");
        upd(pc, 32'd200);
        look(0, pc, 1'b1, 32'd204, "R7 outlier keeps confirmed stride");
        upd(pc, 32'd210);
        look(0, pc, 1'b1, 32'd214, "R6 candidate replaced by new difference");
        upd(pc, 32'd220);
        look(0, pc, 1'b1, 32'd230, "R6 R7 new stride confirmed");
    endtask

    task automatic t_tag_conflict;
        logic [31:0] pa = 32'h0000_0048;
        logic [31:0] pb = 32'h0000_0088;
        upd(pa, 32'd5);
        look(0, pb, 1'b0, '0, "R3 tag mismatch misses");
        look(0, pa, 1'b1, 32'd5, "R3 matching tag hits");
        upd(pb, 32'd9);
        look(0, pa, 1'b0, '0, "R10 old entry evicted");
        look(0, pb, 1'b1, 32'd9, "R10 new entry present");
    endtask

    task automatic t_same_cycle;
        logic [31:0] pc = 32'h0000_0005;
        upd(pc, 32'd7);
        upd(pc, 32'd14);
        upd(pc, 32'd21);
        @(negedge clk);
        lk_en = 1'b1; lk_pc = pc;
        up_en = 1'b1; up_pc = pc; up_result = 32'd28;
        @(negedge clk);
        lk_en = 1'b0; up_en = 1'b0;
        check(pv_a && pval_a == 32'd28, "R8 same-cycle lookup sees old state", pval_a, 32'd28);
        look(0, pc, 1'b1, 32'd35, "R8 following lookup sees update");
    endtask

    task automatic t_wrap;
        logic [31:0] pu = 32'h0000_0006;
        logic [31:0] pd = 32'h0000_0007;
        upd(pu, 32'hFFFF_FFE0);
        upd(pu, 32'hFFFF_FFE8);
        upd(pu, 32'hFFFF_FFF0);
        upd(pu, 32'hFFFF_FFF8);
        look(0, pu, 1'b1, 32'h0000_0000, "R5 forecast wraps past zero");
        upd(pd, 32'd12);
        upd(pd, 32'd7);
        upd(pd, 32'd2);
        look(0, pd, 1'b1, 32'hFFFF_FFFD, "R5 negative stride wraps below zero");
    endtask

    task automatic t_confidence;
        logic [31:0] pc = 32'h0000_0009;
        upd(pc, 32'd10);
        upd(pc, 32'd13);
        look(1, pc, 1'b1, 32'd16, "R9 low counter takes stride at once");
        look(0, pc, 1'b1, 32'd13, "R7 two-delta still waits");
        upd(pc, 32'd16);
        upd(pc, 32'd19);
        upd(pc, 32'd100);
        look(1, pc, 1'b1, 32'd103, "R9 high counter keeps stride");
        upd(pc, 32'd50);
        look(1, pc, 1'b1, 32'd0, "R9 counter dropped below threshold, stride replaced");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_alloc_and_idle();
        t_two_delta();
        t_tag_conflict();
        t_same_cycle();
        t_wrap();
        t_confidence();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule